// File: doc/BRIEF.md
# Three-Wire Serial Memory Target

This block models the target side of a three-wire serial non-volatile memory. A controller selects it with a chip select, clocks command frames in on a serial clock and data input, and reads results or status on a serial data output that can be turned off. Behind the serial port sits a register array of `2**ADDR_W` words of `DATA_W` bits, 64 words of 16 bits by default. At reset every bit of the array is 1.

Each frame starts with a 1 bit. Any zeros clocked in before that 1 are ignored. The start bit is followed by a two-bit opcode, the address and, for commands that carry data, a data word. Commands that change the array are write, erase, erase-all and write-all. None of them takes effect unless a write-enable latch has been set first. Each one runs as an internally timed programming cycle of `PROG_CYCLES` system clocks that starts when chip select falls and needs no further serial clocks. While chip select is high and no read data is being shifted out, the output pin reports status: 0 while busy, 1 when ready. A read command shifts a word out so that the array can be checked through the port.

All pins are sampled on the system clock `clk`. A serial clock edge is recognised when `sk` is seen high after it was seen low.

Top module: `serial_mem_target`

## Requirements
- R1: A frame begins at the first 1 sampled on `di` at a rising `sk` while `cs` is high. Zeros before it are ignored. The start bit is followed by opcode bit 1 then bit 0, then `ADDR_W` address bits MSB first, then (write and write-all only) `DATA_W` data bits MSB first. Taking `cs` low ends the frame.
- R2: The write-enable latch is clear after reset. Opcode 00 with the two address MSBs at 11 sets it, and opcode 00 with 00 clears it, both when `cs` falls. While the latch is clear, write, erase, erase-all and write-all leave the array unchanged and start no cycle.
- R3: Write (opcode 01) stores the data word at the address and replaces the previous contents completely, whatever they were, with no erase needed first.
- R4: Erase (opcode 11) sets every bit of the addressed word to 1 and leaves all other words unchanged.
- R5: Erase-all (opcode 00, address MSBs 10) sets every bit of every word to 1.
- R6: Write-all (opcode 00, address MSBs 01) stores its data word into every word.
- R7: An accepted modifying command starts its cycle on the clock that samples `cs` falling. The target stays busy for exactly `PROG_CYCLES` clocks without needing any `sk` edges.
- R8: While `cs` is low, `dout_en` and `dout` are 0. While `cs` is high and no read data is being shifted out, `dout_en` is 1 and `dout` is 0 when busy and 1 when ready.
- R9: Frames clocked in while the target is busy are ignored and have no effect on the array.
- R10: Read (opcode 10): once the last address bit is captured, `dout` carries the word's MSB. Each further rising `sk` moves it to the next lower bit, and 0 follows the LSB.
- R11: A write or write-all frame whose data bit count is not exactly `DATA_W`, or any other command frame that carries extra bits, is ignored when `cs` falls.
- R12: After reset every word of the array reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, bits captured on its rising edge |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out (read data or ready/busy status) |
| dout_en | output | 1 | Output enable for `dout`. When 0 the pin is high-impedance |

## Verification
The assertions assume that `cs`, `sk` and `di` change only between system clock edges, and that each `sk` level lasts at least one clock, so that every serial edge is seen exactly once. The bench drives every input on the falling clock edge and holds each `sk` level for two clocks. It keeps a frame sent during a busy cycle shorter than `PROG_CYCLES`, so the whole ignored frame falls inside the busy window. The busy-length check counts clocks in the checker itself, because the cycle length is a parameter.

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic dout,
  output logic dout_en
);
  localparam int WORDS    = 1 << ADDR_W;
  localparam int CMD_BITS = 2 + ADDR_W;
  localparam int ALL_BITS = CMD_BITS + DATA_W;
  localparam int CW       = $clog2(ALL_BITS + 2);
  localparam int TW       = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {K_NONE, K_WRITE, K_ERASE, K_ERAL, K_WRAL, K_EN, K_DIS} kind_t;

  logic [DATA_W-1:0]   mem [WORDS];
  logic [ALL_BITS-1:0] sh;
  logic [CW-1:0]       cnt;
  logic [TW-1:0]       tmr;
  logic [DATA_W-1:0]   rd_word, p_data;
  logic [ADDR_W-1:0]   p_addr;
  logic                p_all, started, rd_active, wen, busy, cs_d, sk_d;
  kind_t               kind;

  wire cs_fall = cs_d & ~cs;
  wire sk_rise = sk & ~sk_d;

  wire [1:0]        c_op   = sh[CMD_BITS-1:CMD_BITS-2];
  wire [1:0]        c_sub  = sh[ADDR_W-1:ADDR_W-2];
  wire [ADDR_W-1:0] c_addr = sh[ADDR_W-1:0];
  wire [1:0]        f_op   = sh[ALL_BITS-1:ALL_BITS-2];
  wire [1:0]        f_sub  = sh[ALL_BITS-3:ALL_BITS-4];
  wire [ADDR_W-1:0] f_addr = sh[DATA_W+ADDR_W-1:DATA_W];
  wire [DATA_W-1:0] f_data = sh[DATA_W-1:0];

  wire              rd_hit  = (cnt == CW'(CMD_BITS - 1)) && (sh[CMD_BITS-2:CMD_BITS-3] == 2'b10);
  wire [ADDR_W-1:0] rd_addr = {sh[ADDR_W-2:0], di};

  always_comb begin
    kind = K_NONE;
    if (cnt == CW'(CMD_BITS)) begin
      if (c_op == 2'b11) kind = K_ERASE;
      else if (c_op == 2'b00) begin
        case (c_sub)
          2'b10:   kind = K_ERAL;
          2'b11:   kind = K_EN;
          2'b00:   kind = K_DIS;
          default: kind = K_NONE;
        endcase
      end
    end else if (cnt == CW'(ALL_BITS)) begin
      if (f_op == 2'b01) kind = K_WRITE;
      else if (f_op == 2'b00 && f_sub == 2'b01) kind = K_WRAL;
    end
  end

  assign dout_en = cs;
  assign dout    = cs & (rd_active ? rd_word[DATA_W-1] : ~busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      sh        <= '0;
      cnt       <= '0;
      tmr       <= '0;
      rd_word   <= '0;
      p_data    <= '0;
      p_addr    <= '0;
      p_all     <= 1'b0;
      started   <= 1'b0;
      rd_active <= 1'b0;
      wen       <= 1'b0;
      busy      <= 1'b0;
      cs_d      <= 1'b0;
      sk_d      <= 1'b0;
    end else begin
      cs_d <= cs;
      sk_d <= sk;

      if (busy) begin
        if (tmr == TW'(1)) begin
          busy <= 1'b0;
          if (p_all) for (int i = 0; i < WORDS; i++) mem[i] <= p_data;
          else mem[p_addr] <= p_data;
        end
        tmr <= tmr - TW'(1);
      end

      if (!cs) begin
        started   <= 1'b0;
        cnt       <= '0;
        rd_active <= 1'b0;
      end else if (sk_rise && !busy) begin
        if (!started) begin
          started <= di;
          cnt     <= '0;
        end else if (rd_active) begin
          rd_word <= {rd_word[DATA_W-2:0], 1'b0};
        end else if (cnt < CW'(ALL_BITS)) begin
          sh  <= {sh[ALL_BITS-2:0], di};
          cnt <= cnt + CW'(1);
          if (rd_hit) begin
            rd_active <= 1'b1;
            rd_word   <= mem[rd_addr];
          end
        end else begin
          cnt <= CW'(ALL_BITS + 1);
        end
      end

      if (cs_fall && !busy) begin
        case (kind)
          K_EN:  wen <= 1'b1;
          K_DIS: wen <= 1'b0;
          K_WRITE, K_ERASE, K_ERAL, K_WRAL: if (wen) begin
            busy   <= 1'b1;
            tmr    <= TW'(PROG_CYCLES);
            p_all  <= (kind == K_ERAL) || (kind == K_WRAL);
            p_addr <= (kind == K_WRITE) ? f_addr : c_addr;
            p_data <= (kind == K_WRITE || kind == K_WRAL) ? f_data : '1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_mem_target_chk.sv
module serial_mem_target_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic dout,
  input logic dout_en,
  input logic busy,
  input logic wen,
  input logic rd_active
);
  logic [31:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 32'd1;
    else run <= '0;
  end

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run < PROG_CYCLES);
  assert_busy_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(run) == PROG_CYCLES - 1);
  assert_start_csfall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cs));
  assert_needs_wen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wen));
  assert_busy_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && busy) |-> (dout_en && !dout));
  assert_no_read_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_active);
endmodule

bind serial_mem_target serial_mem_target_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .dout(dout), .dout_en(dout_en),
  .busy(busy), .wen(wen), .rd_active(rd_active)
);

// File: tb/serial_mem_target_test.sv
module serial_mem_target_test;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int P  = 100;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic dout, dout_en;
  logic [DW-1:0] model [NW];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  serial_mem_target #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitout(input logic b);
    di = b; sk = 1'b0;
    @(negedge clk); @(negedge clk);
    sk = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int nd, input int lead);
    cs = 1'b1;
    @(negedge clk);
    for (int i = 0; i < lead; i++) bitout(1'b0);
    bitout(1'b1);
    bitout(op[1]); bitout(op[0]);
    for (int i = AW - 1; i >= 0; i--) bitout(a[i]);
    for (int i = 0; i < nd; i++) bitout(i < DW ? d[DW-1-i] : 1'b0);
  endtask

  task automatic drop_cs();
    @(negedge clk);
    cs = 1'b0; sk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int nd, input int lead);
    send_frame(op, a, d, nd, lead);
    drop_cs();
  endtask

  task automatic wait_ready();
    int n = 0;
    cs = 1'b1;
    @(negedge clk);
    while (dout !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    cs = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic status_now(input string req, input logic exp);
    cs = 1'b1;
    @(negedge clk);
    chk(req, {dout_en, dout}, {1'b1, exp});
    cs = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input string req, input bit tail);
    logic [DW-1:0] v;
    cs = 1'b1;
    @(negedge clk);
    bitout(1'b1); bitout(1'b1); bitout(1'b0);
    for (int i = AW - 1; i >= 0; i--) bitout(a[i]);
    v[DW-1] = dout;
    for (int i = DW - 2; i >= 0; i--) begin
      bitout(1'b0);
      v[i] = dout;
    end
    chk(req, v, model[a]);
    if (tail) begin
      bitout(1'b0);
      chk("R10 zero after LSB", dout, 1'b0);
    end
    drop_cs();
  endtask

  task automatic verify_all(input string req);
    for (int a = 0; a < NW; a++) read_word(AW'(a), req, 1'b0);
  endtask

  function automatic logic [AW-1:0] special(input logic [1:0] s);
    return {s, {(AW-2){1'b0}}};
  endfunction

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    for (int a = 0; a < NW; a++) model[a] = '1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R8 idle off", {dout_en, dout}, 2'b00);
    status_now("R8 ready after reset", 1'b1);
    verify_all("R12 reset contents");

    send(2'b01, 3'd2, 8'h5A, DW, 0);
    status_now("R2 no cycle without enable", 1'b1);
    verify_all("R2 locked write");

    send(2'b00, special(2'b11), '0, 0, 0);

    send_frame(2'b01, 3'd0, 8'd11, DW, 0);
    @(negedge clk); cs = 1'b0; sk = 1'b0;
    @(negedge clk); cs = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (dout === 1'b0 && n < 1000) n++;
      else break;
    end
    chk("R7 busy length", n, P - 1);
    chk("R8 ready drives", {dout_en, dout}, 2'b11);
    cs = 1'b0;
    @(negedge clk); @(negedge clk);
    model[0] = 8'd11;

    for (int a = 1; a < NW; a++) begin
      model[a] = DW'(a * 37 + 11);
      send(2'b01, AW'(a), model[a], DW, 0);
      wait_ready();
    end
    verify_all("R3 write sweep");
    read_word(3'd0, "R10 read with tail", 1'b1);

    model[3] = ~model[3];
    send(2'b01, 3'd3, model[3], DW, 0);
    wait_ready();
    read_word(3'd3, "R3 overwrite", 1'b0);

    send(2'b11, 3'd5, '0, 0, 0);
    wait_ready();
    model[5] = '1;
    verify_all("R4 erase one");

    send(2'b01, 3'd6, 8'h11, DW, 0);
    model[6] = 8'h11;
    cs = 1'b1;
    @(negedge clk);
    send_frame(2'b01, 3'd0, 8'h22, DW, 0);
    chk("R9 still busy", dout, 1'b0);
    drop_cs();
    wait_ready();
    read_word(3'd0, "R9 ignored frame", 1'b0);
    read_word(3'd6, "R9 first write", 1'b0);

    send(2'b01, 3'd1, 8'h00, DW + 1, 0);
    status_now("R11 long frame no cycle", 1'b1);
    send(2'b01, 3'd1, 8'h00, DW - 1, 0);
    status_now("R11 short frame no cycle", 1'b1);
    send(2'b11, 3'd1, 8'h00, 1, 0);
    status_now("R11 padded erase no cycle", 1'b1);
    read_word(3'd1, "R11 word kept", 1'b0);

    send(2'b01, 3'd4, 8'hC3, DW, 3);
    wait_ready();
    model[4] = 8'hC3;
    read_word(3'd4, "R1 leading zeros", 1'b0);

    send(2'b00, special(2'b00), '0, 0, 0);
    send(2'b00, special(2'b10), '0, 0, 0);
    status_now("R2 disabled erase-all", 1'b1);
    verify_all("R2 after disable");

    send(2'b00, special(2'b11), '0, 0, 0);
    send(2'b00, special(2'b10), '0, 0, 0);
    wait_ready();
    for (int a = 0; a < NW; a++) model[a] = '1;
    verify_all("R5 erase all");

    send(2'b00, special(2'b01), 8'h3C, DW, 0);
    wait_ready();
    for (int a = 0; a < NW; a++) model[a] = 8'h3C;
    verify_all("R6 write all");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule